// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of interrupt sources and a processor that has one interrupt input and one active-low acknowledge output. Each source raises a request; the controller records it, picks the most urgent request that is allowed to interrupt, and signals the processor on a single interrupt line. The processor answers with two low pulses on the acknowledge line. The first pulse takes the interrupt line down and locks in the winning request. The second pulse makes the controller place an 8-bit vector number on the data bus, and the processor uses that number to select its handler.

Requests are captured on their rising edge, so a source may pulse for a single cycle. A request that has been acknowledged becomes in service. While it is in service it holds off requests of the same or lower urgency, and higher-urgency requests may still nest on top of it. Software ends a handler with an end-of-interrupt pulse, which retires the most urgent in-service request.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset no request is pending or in service, `int_o` is low, `vec_oe_o` is low and `vec_o` is 0.
- R2: A rising edge on a request input that is held high for one clock cycle is latched. In the next cycle `int_o` is high, provided that request is eligible, and it stays high until an acknowledge sequence starts.
- R3: A request input held high continuously produces only one request. After that request is acknowledged and ended, the held level does not raise `int_o` again.
- R4: The clock after `inta_n_i` is first seen low, `int_o` goes low. It stays low until the second acknowledge pulse has ended.
- R5: During the second low pulse of `inta_n_i`, `vec_oe_o` is high and `vec_o` equals 16 plus the index of the acknowledged request. At all other times `vec_oe_o` is low and `vec_o` is 0.
- R6: When several eligible requests are pending, the one with the lowest index wins. Index 0 is the most urgent.
- R7: The winner is fixed on the first acknowledge pulse. A more urgent request that arrives between the two pulses does not change the vector, and it stays pending.
- R8: An acknowledged request moves to in service. While it is in service, pending requests with the same or a higher index do not raise `int_o`, and requests with a lower index still do.
- R9: A pulse on `eoi_i` clears the in-service request with the lowest index. Requests it was blocking then become eligible.
- R10: If an acknowledge sequence starts with no eligible request, the vector is 16 plus N-1 (23 with the default N=8), and the in-service state is unchanged.
- R11: When an acknowledge sequence ends and another eligible request is pending, `int_o` rises again in the cycle after the second pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_REQ | Request inputs, captured on their rising edge |
| inta_n_i | input | 1 | Active-low acknowledge from the processor |
| eoi_i | input | 1 | End-of-interrupt pulse |
| int_o | output | 1 | Interrupt line to the processor |
| vec_o | output | VEC_W | Vector number, 0 when not driven |
| vec_oe_o | output | 1 | Bus drive enable for `vec_o` |

## Verification
A lost or stuck pending bit appears at `int_o` one cycle after the request edge. A pending bit that was never set keeps the line low, and one that is never cleared makes the line rise again after a sequence. A wrong in-service bit also shows at `int_o`: a later request that should nest stays silent, or a blocked one gets through, and it is visible in the cycle after that request. A frozen index that is corrupted, or that still follows the live winner, is seen only when the second pulse drives the bus, so the checks compare the vector at each second pulse.

// File: rtl/ivc_pkg.sv
// Package: shared types for the vectored interrupt controller.
// Assumes: nothing beyond standard SystemVerilog.
package ivc_pkg;

    // Phase of the two-pulse acknowledge handshake
    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_FIRST  = 2'd1,
        ACK_GAP    = 2'd2,
        ACK_SECOND = 2'd3
    } ack_st_t;

endpackage

// File: rtl/ivc_req_latch.sv
// Module: edge capture and pending storage for the request inputs.
// Assumes: request inputs are already synchronous to clk. A new rising
// edge takes precedence over a clear in the same cycle.
module ivc_req_latch #(
    parameter int N_REQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic [N_REQ-1:0] clr_i,
    output logic [N_REQ-1:0] pend_o
);

    logic [N_REQ-1:0] req_q;
    logic [N_REQ-1:0] rise;

    // Rising-edge detect against the previous sample
    always_comb rise = req_i & ~req_q;

    // Hold the previous request level
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    // Set pending bits on an edge, drop them when acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_i) | rise;
    end

endmodule

// File: rtl/ivc_prio_enc.sv
// Module: fixed-priority encoder, lowest set index wins.
// Assumes: N_REQ >= 2. The index is 0 when no bit is set.
module ivc_prio_enc #(
    parameter int N_REQ = 8,
    localparam int IW   = $clog2(N_REQ)
) (
    input  logic [N_REQ-1:0] vec_i,
    output logic             hit_o,
    output logic [IW-1:0]    idx_o
);

    // Scan from the lowest urgency down so the lowest index is the last to win
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                hit_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ivc_ack_fsm.sv
// Module: tracks the two low pulses of the acknowledge line.
// Assumes: inta_n_i is synchronous to clk and each pulse lasts at least one
// clock cycle.
module ivc_ack_fsm
    import ivc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inta_n_i,
    output logic first_o,
    output logic busy_o,
    output logic drive_o
);

    ack_st_t st_q;
    ack_st_t st_d;

    // Next-phase decode
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACK_IDLE:   if (!inta_n_i) st_d = ACK_FIRST;
            ACK_FIRST:  if (inta_n_i)  st_d = ACK_GAP;
            ACK_GAP:    if (!inta_n_i) st_d = ACK_SECOND;
            ACK_SECOND: if (inta_n_i)  st_d = ACK_IDLE;
            default:                   st_d = ACK_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ACK_IDLE;
        else        st_q <= st_d;
    end

    // Outputs derived from the phase and the live line
    always_comb begin
        first_o = (st_q == ACK_IDLE) && !inta_n_i;
        busy_o  = (st_q != ACK_IDLE);
        drive_o = (st_q == ACK_SECOND) && !inta_n_i;
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
// Module: prioritized vectored interrupt controller (top).
// Assumes: all inputs are synchronous to clk, and VEC_BASE + N_REQ - 1 fits
// in VEC_W bits. Index 0 is the most urgent request.
module vec_irq_ctrl #(
    parameter int N_REQ    = 8,
    parameter int VEC_BASE = 16,
    parameter int VEC_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic             inta_n_i,
    input  logic             eoi_i,
    output logic             int_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_oe_o
);

    localparam int IW = $clog2(N_REQ);
    localparam logic [IW-1:0] SPUR_IDX = IW'(N_REQ - 1);

    logic [N_REQ-1:0] pend;
    logic [N_REQ-1:0] isr;
    logic [N_REQ-1:0] elig;
    logic [N_REQ-1:0] ack_clr;
    logic [N_REQ-1:0] eoi_clr;
    logic             win_hit;
    logic [IW-1:0]    win_idx;
    logic             isr_hit;
    logic [IW-1:0]    isr_idx;
    logic             first;
    logic             busy;
    logic             drive;
    logic [IW-1:0]    vec_idx_q;

    ivc_req_latch #(.N_REQ(N_REQ)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .clr_i  (ack_clr),
        .pend_o (pend)
    );

    ivc_ack_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .inta_n_i (inta_n_i),
        .first_o  (first),
        .busy_o   (busy),
        .drive_o  (drive)
    );

    // Mask off pending bits at or below the urgency of any in-service bit
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = 0; i < N_REQ; i++) begin
            if (isr[i]) blocked = 1'b1;
            elig[i] = pend[i] && !blocked;
        end
    end

    ivc_prio_enc #(.N_REQ(N_REQ)) u_win (
        .vec_i (elig),
        .hit_o (win_hit),
        .idx_o (win_idx)
    );

    ivc_prio_enc #(.N_REQ(N_REQ)) u_top_isr (
        .vec_i (isr),
        .hit_o (isr_hit),
        .idx_o (isr_idx)
    );

    // One-hot clear and set masks for acknowledge and end-of-interrupt
    always_comb begin
        ack_clr = '0;
        eoi_clr = '0;
        if (first && win_hit) ack_clr[win_idx] = 1'b1;
        if (eoi_i && isr_hit) eoi_clr[isr_idx] = 1'b1;
    end

    // In-service register: retire on end-of-interrupt, enter on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~eoi_clr) | ack_clr;
    end

    // Freeze the winning index at the first acknowledge pulse
    always_ff @(posedge clk) begin
        if (!rst_n)     vec_idx_q <= '0;
        else if (first) vec_idx_q <= win_hit ? win_idx : SPUR_IDX;
    end

    // Interrupt line and vector bus
    always_comb begin
        int_o    = win_hit && !busy;
        vec_oe_o = drive;
        vec_o    = drive ? (VEC_W'(VEC_BASE) + VEC_W'(vec_idx_q)) : '0;
    end

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
// Module: property checker for vec_irq_ctrl, attached by bind.
// Assumes: sees the pending register and the ports of the top module.
module vec_irq_ctrl_chk #(
    parameter int N_REQ    = 8,
    parameter int VEC_BASE = 16,
    parameter int VEC_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req_i,
    input logic             inta_n_i,
    input logic             int_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             vec_oe_o,
    input logic [N_REQ-1:0] pend
);

    AST_OE_IN_LOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> !inta_n_i); // R5

    AST_BUS_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe_o |-> (vec_o == '0)); // R5

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> (vec_o >= VEC_W'(VEC_BASE) && vec_o < VEC_W'(VEC_BASE + N_REQ))); // R5

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe_o && $past(vec_oe_o)) |-> $stable(vec_o)); // R7

    AST_INT_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inta_n_i) |=> !int_o); // R4

    for (genvar k = 0; k < N_REQ; k++) begin : g_edge
        AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(req_i[k]) && inta_n_i) |=> pend[k]); // R2
    end

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
    .N_REQ(N_REQ), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .inta_n_i (inta_n_i),
    .int_o    (int_o),
    .vec_o    (vec_o),
    .vec_oe_o (vec_oe_o),
    .pend     (pend)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;

    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam int BASE  = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic         inta_n_i = 1'b1;
    logic         eoi_i = 1'b0;
    logic         int_o;
    logic [7:0]   vec_o;
    logic         vec_oe_o;

    int total = 0;
    int bad = 0;
    logic [N-1:0] pend_m = '0;
    logic [N-1:0] isr_m = '0;

    vec_irq_ctrl #(.N_REQ(N), .VEC_BASE(BASE), .VEC_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .inta_n_i(inta_n_i),
        .eoi_i(eoi_i), .int_o(int_o), .vec_o(vec_o), .vec_oe_o(vec_oe_o)
    );

    always #(CLK_P / 2) clk = ~clk;

    function automatic int low_idx(logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [N-1:0] elig_of(logic [N-1:0] p, logic [N-1:0] s);
        logic [N-1:0] r;
        logic blk;
        blk = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (s[i]) blk = 1'b1;
            r[i] = p[i] && !blk;
        end
        return r;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // One-cycle request pulse and optional end-of-interrupt, then an idle cycle
    task automatic pulse(logic [N-1:0] m, logic e);
        req_i = m;
        eoi_i = e;
        @(posedge clk);
        pend_m = pend_m | m;
        if (e && isr_m != '0) isr_m[low_idx(isr_m)] = 1'b0;
        @(negedge clk);
        req_i = '0;
        eoi_i = 1'b0;
        tick();
    endtask

    // Full two-pulse acknowledge; returns the vector seen on the bus
    task automatic ack_seq(output int v);
        int w;
        w = low_idx(elig_of(pend_m, isr_m));
        if (w >= 0) begin
            pend_m[w] = 1'b0;
            isr_m[w] = 1'b1;
        end
        inta_n_i = 1'b0;
        tick();
        check("R4 int low after first pulse", int_o, 0);
        inta_n_i = 1'b1;
        tick();
        inta_n_i = 1'b0;
        tick();
        check("R5 drive enable in second pulse", vec_oe_o, 1);
        v = vec_o;
        inta_n_i = 1'b1;
        #1;
        check("R5 enable off after pulse", vec_oe_o, 0);
        check("R5 bus zero after pulse", vec_o, 0);
        tick();
    endtask

    initial begin
        int v;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        check("R1 int after reset", int_o, 0);
        check("R1 oe after reset", vec_oe_o, 0);
        check("R1 vec after reset", vec_o, 0);
        rst_n = 1'b1;
        tick();
        check("R1 int idle", int_o, 0);

        // Single pulse on request 3
        pulse(8'h08, 1'b0);
        check("R2 pulse latched", int_o, 1);
        tick();
        check("R2 int held", int_o, 1);
        ack_seq(v);
        check("R5 vector of req3", v, BASE + 3);
        check("R11 no other pending", int_o, 0);
        pulse('0, 1'b1);

        // Simultaneous requests 2, 5, 6
        pulse(8'h64, 1'b0);
        ack_seq(v);
        check("R6 lowest index wins", v, BASE + 2);
        check("R8 lower urgency blocked", int_o, 0);
        pulse('0, 1'b1);
        check("R9 eoi releases blocked", int_o, 1);
        ack_seq(v);
        check("R6 next winner", v, BASE + 5);
        pulse('0, 1'b1);
        ack_seq(v);
        check("R6 last winner", v, BASE + 6);
        pulse('0, 1'b1);

        // Winner frozen across a more urgent arrival between pulses
        pulse(8'h10, 1'b0);
        pend_m[4] = 1'b0;
        isr_m[4] = 1'b1;
        inta_n_i = 1'b0;
        tick();
        inta_n_i = 1'b1;
        req_i = 8'h02;
        @(posedge clk);
        @(negedge clk);
        req_i = '0;
        pend_m[1] = 1'b1;
        #1;
        check("R4 int low in gap", int_o, 0);
        inta_n_i = 1'b0;
        tick();
        check("R7 vector frozen", vec_o, BASE + 4);
        inta_n_i = 1'b1;
        tick();
        check("R11 int back after sequence", int_o, 1);
        ack_seq(v);
        check("R8 nested higher request", v, BASE + 1);
        pulse('0, 1'b1);
        pulse(8'h20, 1'b0);
        check("R9 eoi cleared only req1", int_o, 0);
        pulse('0, 1'b1);
        check("R9 second eoi releases req5", int_o, 1);
        ack_seq(v);
        check("R5 vector of req5", v, BASE + 5);
        pulse('0, 1'b1);

        // Level held high on request 0
        req_i = 8'h01;
        tick();
        check("R3 level first request", int_o, 1);
        ack_seq(v);
        check("R3 vector of req0", v, BASE + 0);
        eoi_i = 1'b1;
        tick();
        eoi_i = 1'b0;
        isr_m = '0;
        repeat (3) tick();
        check("R3 held level no repeat", int_o, 0);
        req_i = '0;
        tick();

        // Acknowledge with nothing pending
        ack_seq(v);
        check("R10 spurious vector", v, BASE + N - 1);
        pulse(8'h80, 1'b0);
        check("R10 in-service untouched", int_o, 1);
        ack_seq(v);
        check("R6 req7 vector", v, BASE + 7);
        pulse('0, 1'b1);

        // Random mix against the bench model
        for (int it = 0; it < 120; it++) begin
            logic [N-1:0] m;
            logic e;
            logic exp_int;
            m = N'($urandom_range(0, 255) & $urandom_range(0, 255));
            e = ($urandom_range(0, 3) == 0);
            pulse(m, e);
            exp_int = |elig_of(pend_m, isr_m);
            check("R8 random int level", int_o, int'(exp_int));
            if (exp_int && $urandom_range(0, 1) == 1) begin
                int w;
                w = low_idx(elig_of(pend_m, isr_m));
                ack_seq(v);
                check("R6 random vector", v, BASE + w);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule